// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block holds the architectural-to-physical register mapping of an out-of-order core. Six register classes are renamed, each with its own mapping table and its own free list of physical tags: integer, floating point, whole vector, vector element, predicate and condition code. A seventh class, control registers, is never renamed. Each control register keeps a fixed tag.

The rename port takes a fresh tag from the class's free list. It returns that tag together with the tag it replaces, and the table holds the new mapping from the next clock edge. The lookup port reads the current mapping combinationally. The write port sets a mapping directly when the core commits or squashes. The release port hands a freed tag back to its class's free list. Per-class free counts are reported, along with their minimum and a flag that says whether a whole bundle of per-class demands fits. An input selects whole-vector or per-element vector renaming, and only the selected vector class may be used.

A physical tag is `{class[2:0], index[PW-1:0]}`. The class codes are 0 integer, 1 floating point, 2 whole vector, 3 vector element, 4 predicate, 5 condition code, 6 control and 7 invalid.

Top module: `rn_rename_table`

## Requirements
- R1: After reset, architectural register i of every renamable class maps to tag {class, i}. Each free list then holds PHYS_REGS-ARCH_REGS tags, in ascending order starting at ARCH_REGS.
- R2: An accepted rename of a renamable class returns the free-list head as the new tag and the current mapping as the old tag. The mapping becomes the new tag at the next edge, and that class's free count drops by one.
- R3: Lookup is combinational. A lookup of an entry that is being renamed in the same cycle returns the pre-rename mapping.
- R4: A rename of a control register (class 6) returns {6, idx} as both the new and the old tag, with ren_ready high. No free count changes.
- R5: The write port sets the mapping only when the tag's class field equals wr_class. On a mismatch it raises wr_err and changes nothing. When the write port and a rename hit the same entry in the same cycle, the write port's tag is the one kept.
- R6: A write to a control register with tag {6, idx} is accepted with no error and no effect. Any other tag raises wr_err.
- R7: With vec_mode=0 (whole) class 3 is illegal. With vec_mode=1 (element) class 2 is illegal. Illegal use raises the port's error output, holds ren_ready low and changes no state.
- R8: Class code 7 on any port raises that port's error output and changes no state.
- R9: free_min is the minimum of the integer, floating point, predicate and condition-code counts together with one vector term. That term is the whole-vector count when vec_mode=0 and the element count when vec_mode=1.
- R10: bundle_ok is high only when every one of the six per-class demands is less than or equal to that class's free count.
- R11: A rename to a class whose free list is empty holds ren_ready low and changes neither the table nor the count.
- R12: A released tag is appended to the free list of its class. A release and a rename of the same class in the same cycle both complete, and the count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode | input | 1 | 0 whole-vector renaming, 1 per-element renaming |
| ren_valid | input | 1 | Rename request |
| ren_class | input | 3 | Class of the register to rename |
| ren_idx | input | AW | Architectural index to rename |
| ren_ready | output | 1 | Rename accepted |
| ren_new_tag | output | TW | Newly assigned tag |
| ren_old_tag | output | TW | Tag replaced by the rename |
| ren_err | output | 1 | Illegal rename class |
| lk_class | input | 3 | Lookup class |
| lk_idx | input | AW | Lookup index |
| lk_tag | output | TW | Current mapping |
| lk_err | output | 1 | Illegal lookup class |
| wr_valid | input | 1 | Direct mapping write |
| wr_class | input | 3 | Write class |
| wr_idx | input | AW | Write index |
| wr_tag | input | TW | Tag to install |
| wr_err | output | 1 | Write rejected |
| rel_valid | input | 1 | Tag release |
| rel_tag | input | TW | Tag returned to its class's free list |
| bundle_need | input | 6*CW | Per-class demand, class c in slice c |
| bundle_ok | output | 1 | Whole bundle fits |
| free_cnt | output | 6*CW | Per-class free counts, class c in slice c |
| free_min | output | CW | Minimum free count for the active vector mode |

## Verification
Renames are exercised on a plain integer entry, on a control register, on both vector classes under each mode value, on the invalid code and on a class drained to empty. These cases separate a real allocation from the fixed pass-through and a legal request from a refused one. Write-port patterns include a matching tag, a tag of the wrong class, a control-register write with a right and a wrong tag, and a write that collides with a rename. These show class checking and the priority between writers. Free-list order is checked through the sequence of tags handed out, including after a release. free_min is read under both modes with unequal vector counts, and bundle_ok is driven with demands set exactly at, and one above, the available counts.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    RC_INT  = 3'd0,
    RC_FP   = 3'd1,
    RC_VEC  = 3'd2,
    RC_ELEM = 3'd3,
    RC_PRED = 3'd4,
    RC_CC   = 3'd5,
    RC_CTRL = 3'd6,
    RC_BAD  = 3'd7
  } rclass_e;

  localparam int NREN = 6;

  // Class is usable on a port under the given vector mode
  function automatic logic cls_legal(input logic [2:0] cls, input logic mode);
    case (cls)
      3'd0, 3'd1, 3'd4, 3'd5, 3'd6: cls_legal = 1'b1;
      3'd2:                         cls_legal = ~mode;
      3'd3:                         cls_legal = mode;
      default:                      cls_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_idx,
  output logic [PW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty
);
  localparam int DEPTH = PHYS_REGS;
  localparam int FREE0 = PHYS_REGS - ARCH_REGS;

  logic [PW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          push_ok;

  assign empty   = (count == '0);
  assign head    = mem[rd_ptr];
  assign push_ok = push && ((count != CW'(DEPTH)) || pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < FREE0) ? PW'(i + ARCH_REGS) : '0;
    end else if (push_ok) begin
      mem[wr_ptr] <= push_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= PW'(FREE0);
      count  <= CW'(FREE0);
    end else begin
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop);
    end
  end

  // R11
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R12
  push_pop_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && push) |=> $stable(count));
  // R2
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_idx,
  output logic [PW-1:0] ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [PW-1:0] rb_data,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_idx,
  input  logic [PW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_idx,
  input  logic [PW-1:0] wb_data
);
  logic [PW-1:0] mem [ARCH_REGS];

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];

  // Write port B (commit/squash) is applied last and so wins a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) mem[i] <= PW'(i);
    end else begin
      if (wa_en) mem[wa_idx] <= wa_data;
      if (wb_en) mem[wb_idx] <= wb_data;
    end
  end

  // R2
  rename_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wa_en && !(wb_en && wb_idx == wa_idx)) |=> (mem[$past(wa_idx)] == $past(wa_data)));
  // R5
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> (mem[$past(wb_idx)] == $past(wb_data)));
endmodule

// File: rtl/rn_rename_table.sv
module rn_rename_table
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int TW = PW + 3,
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vec_mode,
  input  logic             ren_valid,
  input  logic [2:0]       ren_class,
  input  logic [AW-1:0]    ren_idx,
  output logic             ren_ready,
  output logic [TW-1:0]    ren_new_tag,
  output logic [TW-1:0]    ren_old_tag,
  output logic             ren_err,
  input  logic [2:0]       lk_class,
  input  logic [AW-1:0]    lk_idx,
  output logic [TW-1:0]    lk_tag,
  output logic             lk_err,
  input  logic             wr_valid,
  input  logic [2:0]       wr_class,
  input  logic [AW-1:0]    wr_idx,
  input  logic [TW-1:0]    wr_tag,
  output logic             wr_err,
  input  logic             rel_valid,
  input  logic [TW-1:0]    rel_tag,
  input  logic [6*CW-1:0]  bundle_need,
  output logic             bundle_ok,
  output logic [6*CW-1:0]  free_cnt,
  output logic [CW-1:0]    free_min
);
  logic [PW-1:0] head_v [NREN];
  logic [CW-1:0] cnt_v  [NREN];
  logic [NREN-1:0] empty_v;
  logic [PW-1:0] ren_rd_v [NREN];
  logic [PW-1:0] lk_rd_v  [NREN];
  logic [NREN-1:0] pop_v, push_v, wr_en_v;

  logic ren_legal, ren_is_ctrl, ren_fire;
  logic wr_ok;
  logic [2:0] rel_cls;
  logic [PW-1:0] ren_fix, lk_fix, wr_fix;

  assign ren_fix = PW'(ren_idx);
  assign lk_fix  = PW'(lk_idx);
  assign wr_fix  = PW'(wr_idx);

  // Rename admission
  assign ren_legal   = cls_legal(ren_class, vec_mode);
  assign ren_is_ctrl = (ren_class == RC_CTRL);
  assign ren_err     = ren_valid && !ren_legal;

  always_comb begin
    ren_ready   = 1'b0;
    ren_new_tag = '0;
    ren_old_tag = '0;
    if (ren_legal) begin
      if (ren_is_ctrl) begin
        ren_ready   = 1'b1;
        ren_new_tag = {RC_CTRL, ren_fix};
        ren_old_tag = {RC_CTRL, ren_fix};
      end else begin
        for (int c = 0; c < NREN; c++) begin
          if (ren_class == 3'(c)) begin
            ren_ready   = !empty_v[c];
            ren_new_tag = {3'(c), head_v[c]};
            ren_old_tag = {3'(c), ren_rd_v[c]};
          end
        end
      end
    end
  end

  assign ren_fire = ren_valid && ren_ready && !ren_is_ctrl;

  // Lookup
  assign lk_err = !cls_legal(lk_class, vec_mode);

  always_comb begin
    lk_tag = '0;
    if (!lk_err) begin
      if (lk_class == RC_CTRL) begin
        lk_tag = {RC_CTRL, lk_fix};
      end else begin
        for (int c = 0; c < NREN; c++)
          if (lk_class == 3'(c)) lk_tag = {3'(c), lk_rd_v[c]};
      end
    end
  end

  // Direct write (commit / squash)
  always_comb begin
    wr_ok = cls_legal(wr_class, vec_mode) && (wr_tag[TW-1:PW] == wr_class);
    if (wr_class == RC_CTRL) wr_ok = wr_ok && (wr_tag[PW-1:0] == wr_fix);
  end
  assign wr_err = wr_valid && !wr_ok;

  assign rel_cls = rel_tag[TW-1:PW];

  for (genvar c = 0; c < NREN; c++) begin : g_cls
    assign pop_v[c]   = ren_fire && (ren_class == 3'(c));
    assign push_v[c]  = rel_valid && (rel_cls == 3'(c));
    assign wr_en_v[c] = wr_valid && wr_ok && (wr_class == 3'(c));

    rn_free_fifo #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
      .clk      (clk),
      .rst      (rst),
      .pop      (pop_v[c]),
      .push     (push_v[c]),
      .push_idx (rel_tag[PW-1:0]),
      .head     (head_v[c]),
      .count    (cnt_v[c]),
      .empty    (empty_v[c])
    );

    rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
      .clk     (clk),
      .rst     (rst),
      .ra_idx  (ren_idx),
      .ra_data (ren_rd_v[c]),
      .rb_idx  (lk_idx),
      .rb_data (lk_rd_v[c]),
      .wa_en   (pop_v[c]),
      .wa_idx  (ren_idx),
      .wa_data (head_v[c]),
      .wb_en   (wr_en_v[c]),
      .wb_idx  (wr_idx),
      .wb_data (wr_tag[PW-1:0])
    );

    assign free_cnt[c*CW +: CW] = cnt_v[c];
  end

  // Aggregate free count and bundle admission
  always_comb begin
    logic [CW-1:0] vterm;
    vterm    = vec_mode ? cnt_v[RC_ELEM] : cnt_v[RC_VEC];
    free_min = vterm;
    if (cnt_v[RC_INT]  < free_min) free_min = cnt_v[RC_INT];
    if (cnt_v[RC_FP]   < free_min) free_min = cnt_v[RC_FP];
    if (cnt_v[RC_PRED] < free_min) free_min = cnt_v[RC_PRED];
    if (cnt_v[RC_CC]   < free_min) free_min = cnt_v[RC_CC];
  end

  always_comb begin
    bundle_ok = 1'b1;
    for (int c = 0; c < NREN; c++)
      if (bundle_need[c*CW +: CW] > cnt_v[c]) bundle_ok = 1'b0;
  end

  // R4
  ctrl_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_class == RC_CTRL) |-> (ren_ready && ren_new_tag == ren_old_tag));
  // R8
  bad_class_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_class == RC_BAD) |-> (ren_err && !ren_ready));
  // R9
  min_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (free_min <= cnt_v[RC_INT]) && (free_min <= cnt_v[RC_CC]));
  // R10
  bundle_int_chk: assert property (@(posedge clk) disable iff (rst)
    bundle_ok |-> (bundle_need[CW-1:0] <= cnt_v[RC_INT]));
  // R7
  mode_block_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_err) |=> $stable(free_cnt));
endmodule

// File: tb/sim_rn_rename_table.sv
module sim_rn_rename_table;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int PW = 4;
  localparam int TW = 7;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vec_mode = 1'b0;
  logic ren_valid = 1'b0;
  logic [2:0] ren_class = '0;
  logic [AW-1:0] ren_idx = '0;
  logic ren_ready, ren_err, lk_err, wr_err, bundle_ok;
  logic [TW-1:0] ren_new_tag, ren_old_tag, lk_tag;
  logic [2:0] lk_class = '0;
  logic [AW-1:0] lk_idx = '0;
  logic wr_valid = 1'b0;
  logic [2:0] wr_class = '0;
  logic [AW-1:0] wr_idx = '0;
  logic [TW-1:0] wr_tag = '0;
  logic rel_valid = 1'b0;
  logic [TW-1:0] rel_tag = '0;
  logic [6*CW-1:0] bundle_need = '0;
  logic [6*CW-1:0] free_cnt;
  logic [CW-1:0] free_min;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rn_rename_table #(.ARCH_REGS(8), .PHYS_REGS(16)) u0 (
    .clk(clk), .rst(rst), .vec_mode(vec_mode),
    .ren_valid(ren_valid), .ren_class(ren_class), .ren_idx(ren_idx),
    .ren_ready(ren_ready), .ren_new_tag(ren_new_tag), .ren_old_tag(ren_old_tag),
    .ren_err(ren_err), .lk_class(lk_class), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .lk_err(lk_err), .wr_valid(wr_valid), .wr_class(wr_class), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_err(wr_err), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .bundle_need(bundle_need), .bundle_ok(bundle_ok), .free_cnt(free_cnt),
    .free_min(free_min)
  );

  function automatic logic [TW-1:0] tg(input int c, input int i);
    return {3'(c), 4'(i)};
  endfunction

  function automatic int cnt(input int c);
    return int'(free_cnt[c*CW +: CW]);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 1'b0; wr_valid = 1'b0; rel_valid = 1'b0;
  endtask

  // Drive on the falling edge, settle, then check before the next rising edge
  task automatic drive_edge();
    @(negedge clk); #1;
  endtask

  task automatic check_counts(input string req, input int a, input int b, input int v,
                              input int e, input int p, input int q);
    check(req, "int count", cnt(0), a);
    check(req, "fp count", cnt(1), b);
    check(req, "vec count", cnt(2), v);
    check(req, "elem count", cnt(3), e);
    check(req, "pred count", cnt(4), p);
    check(req, "cc count", cnt(5), q);
  endtask

  task automatic t_reset();
    for (int c = 0; c < 6; c++) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        vec_mode = (c == 3); lk_class = 3'(c); lk_idx = 3'(i); #1;
        check("R1", "identity map", int'(lk_tag), int'(tg(c, i)));
      end
    end
    vec_mode = 1'b0;
    #1;
    check_counts("R1", 8, 8, 8, 8, 8, 8);
    check("R9", "min at reset", int'(free_min), 8);
  endtask

  task automatic t_rename_int();
    drive_edge();
    ren_valid = 1'b1; ren_class = 3'd0; ren_idx = 3'd3;
    lk_class = 3'd0; lk_idx = 3'd3; #1;
    check("R2", "ready", int'(ren_ready), 1);
    check("R2", "new tag", int'(ren_new_tag), int'(tg(0, 8)));
    check("R2", "old tag", int'(ren_old_tag), int'(tg(0, 3)));
    check("R3", "lookup same cycle", int'(lk_tag), int'(tg(0, 3)));
    drive_edge(); idle(); #1;
    check("R2", "mapping after", int'(lk_tag), int'(tg(0, 8)));
    check("R2", "int count", cnt(0), 7);
    ren_valid = 1'b1; ren_class = 3'd0; ren_idx = 3'd3; #1;
    check("R2", "second new", int'(ren_new_tag), int'(tg(0, 9)));
    check("R2", "second old", int'(ren_old_tag), int'(tg(0, 8)));
    drive_edge(); idle(); #1;
    check("R2", "int count 2", cnt(0), 6);
  endtask

  task automatic t_ctrl();
    drive_edge();
    ren_valid = 1'b1; ren_class = 3'd6; ren_idx = 3'd5; #1;
    check("R4", "ready", int'(ren_ready), 1);
    check("R4", "new", int'(ren_new_tag), int'(tg(6, 5)));
    check("R4", "old", int'(ren_old_tag), int'(tg(6, 5)));
    drive_edge(); idle(); #1;
    check_counts("R4", 6, 8, 8, 8, 8, 8);
    lk_class = 3'd6; lk_idx = 3'd5; #1;
    check("R4", "ctrl lookup", int'(lk_tag), int'(tg(6, 5)));
    wr_valid = 1'b1; wr_class = 3'd6; wr_idx = 3'd5; wr_tag = tg(6, 5); #1;
    check("R6", "match err", int'(wr_err), 0);
    wr_tag = tg(6, 4); #1;
    check("R6", "mismatch err", int'(wr_err), 1);
    drive_edge(); idle(); #1;
    check("R6", "ctrl map kept", int'(lk_tag), int'(tg(6, 5)));
  endtask

  task automatic t_write();
    drive_edge();
    wr_valid = 1'b1; wr_class = 3'd1; wr_idx = 3'd2; wr_tag = tg(1, 12); #1;
    check("R5", "good write err", int'(wr_err), 0);
    drive_edge(); idle();
    lk_class = 3'd1; lk_idx = 3'd2; #1;
    check("R5", "written map", int'(lk_tag), int'(tg(1, 12)));
    wr_valid = 1'b1; wr_class = 3'd1; wr_idx = 3'd2; wr_tag = tg(0, 3); #1;
    check("R5", "class mismatch err", int'(wr_err), 1);
    drive_edge(); idle(); #1;
    check("R5", "map unchanged", int'(lk_tag), int'(tg(1, 12)));
    ren_valid = 1'b1; ren_class = 3'd1; ren_idx = 3'd1;
    wr_valid = 1'b1; wr_class = 3'd1; wr_idx = 3'd1; wr_tag = tg(1, 13); #1;
    check("R5", "collide rename new", int'(ren_new_tag), int'(tg(1, 8)));
    drive_edge(); idle();
    lk_class = 3'd1; lk_idx = 3'd1; #1;
    check("R5", "write wins", int'(lk_tag), int'(tg(1, 13)));
    check("R5", "fp count", cnt(1), 7);
  endtask

  task automatic t_mode();
    drive_edge();
    vec_mode = 1'b0; ren_valid = 1'b1; ren_class = 3'd3; ren_idx = 3'd0; #1;
    check("R7", "elem in whole err", int'(ren_err), 1);
    check("R7", "elem in whole ready", int'(ren_ready), 0);
    drive_edge(); idle();
    vec_mode = 1'b1; lk_class = 3'd3; lk_idx = 3'd0; #1;
    check("R7", "elem count kept", cnt(3), 8);
    check("R7", "elem map kept", int'(lk_tag), int'(tg(3, 0)));
    ren_valid = 1'b1; ren_class = 3'd2; ren_idx = 3'd0; lk_class = 3'd2; #1;
    check("R7", "vec in elem err", int'(ren_err), 1);
    check("R7", "vec lookup err", int'(lk_err), 1);
    drive_edge(); idle(); #1;
    check("R7", "vec count kept", cnt(2), 8);
    vec_mode = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ren_valid = 1'b1; ren_class = 3'd2; ren_idx = 3'(i);
      drive_edge();
    end
    idle(); #1;
    check("R7", "vec renamed", cnt(2), 5);
    check("R9", "min whole mode", int'(free_min), 5);
    vec_mode = 1'b1; #1;
    check("R9", "min elem mode", int'(free_min), 6);
    vec_mode = 1'b0;
  endtask

  task automatic t_unknown();
    drive_edge();
    ren_valid = 1'b1; ren_class = 3'd7; ren_idx = 3'd0;
    wr_valid = 1'b1; wr_class = 3'd7; wr_idx = 3'd0; wr_tag = tg(7, 0);
    lk_class = 3'd7; #1;
    check("R8", "ren err", int'(ren_err), 1);
    check("R8", "ren ready", int'(ren_ready), 0);
    check("R8", "wr err", int'(wr_err), 1);
    check("R8", "lk err", int'(lk_err), 1);
    drive_edge(); idle(); #1;
    check_counts("R8", 6, 7, 5, 8, 8, 8);
  endtask

  task automatic t_bundle();
    drive_edge();
    bundle_need = '0; bundle_need[0*CW +: CW] = 5'd6; #1;
    check("R10", "int exact", int'(bundle_ok), 1);
    bundle_need[0*CW +: CW] = 5'd7; #1;
    check("R10", "int over", int'(bundle_ok), 0);
    bundle_need = '0; bundle_need[2*CW +: CW] = 5'd6; vec_mode = 1'b1; #1;
    check("R10", "vec over in elem mode", int'(bundle_ok), 0);
    bundle_need = {5'd8, 5'd8, 5'd8, 5'd5, 5'd7, 5'd6}; #1;
    check("R10", "all exact", int'(bundle_ok), 1);
    bundle_need = '0; vec_mode = 1'b0;
  endtask

  task automatic t_empty_release();
    for (int i = 0; i < 8; i++) begin
      drive_edge();
      ren_valid = 1'b1; ren_class = 3'd4; ren_idx = 3'd0; #1;
      if (i == 7) check("R2", "last pred new", int'(ren_new_tag), int'(tg(4, 15)));
    end
    drive_edge(); #1;
    check("R11", "empty ready", int'(ren_ready), 0);
    drive_edge(); idle();
    lk_class = 3'd4; lk_idx = 3'd0; #1;
    check("R11", "map kept", int'(lk_tag), int'(tg(4, 15)));
    check("R11", "count zero", cnt(4), 0);
    rel_valid = 1'b1; rel_tag = tg(4, 8);
    drive_edge(); idle(); #1;
    check("R12", "after release", cnt(4), 1);
    ren_valid = 1'b1; ren_class = 3'd4; ren_idx = 3'd1;
    rel_valid = 1'b1; rel_tag = tg(4, 9); #1;
    check("R12", "released tag out", int'(ren_new_tag), int'(tg(4, 8)));
    check("R12", "old tag", int'(ren_old_tag), int'(tg(4, 1)));
    drive_edge(); idle(); #1;
    check("R12", "count same", cnt(4), 1);
    ren_valid = 1'b1; ren_class = 3'd4; ren_idx = 3'd2; #1;
    check("R12", "next in order", int'(ren_new_tag), int'(tg(4, 9)));
    drive_edge(); idle(); #1;
    check("R12", "count drained", cnt(4), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_rename_int();
    t_ctrl();
    t_write();
    t_mode();
    t_unknown();
    t_bundle();
    t_empty_release();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule